// File: doc/BRIEF.md
# Posted Write Transaction Queue

This block sits on the bridge between an external bus target and an internal bus master. It holds posted memory write bursts until the internal side can send them. There are two stores. The first is a shared data buffer of 4096 bytes, kept as 512 beats of 64 bits, with the byte enables stored beside each beat. The second is a four-entry queue of transaction descriptors. Each descriptor holds the start address, the byte count received and the command type.

On the ingress side, a new write is claimed with `in_start`. The block answers with a single-cycle accept or retry. Data beats then follow on a valid/last handshake. When the data buffer runs out of room mid-burst, the block ends the burst early with `in_stop`. In conventional mode the stop comes on the beat that fills the buffer. In extended mode it comes on the last beat before a 128-byte aligned boundary, once no further full window would fit. The truncated transaction is closed with the bytes actually received, and the master reissues the rest as a new write.

On the egress side, whole transactions are replayed in arrival order once `out_grant` is high. A transaction is retired only after its final beat is taken. `out_abort` cancels the transaction at the head and nothing else.

Top module: `posted_wr_queue`

## Requirements
- R1: After reset, `in_accept`, `in_retry`, `in_stop`, `out_busy`, `out_valid` and `out_last` are all low.
- R2: An `in_start` seen while no burst is open gets exactly one response, one cycle later. The response is `in_accept` when fewer than 4 transactions are resident and at least one beat of buffer is free; otherwise it is `in_retry`. Buffer space beyond one beat does not gate admission.
- R3: The buffer never holds more than 512 beats (4096 bytes), counting resident and partly received transactions.
- R4: In conventional mode (`pcix_mode`=0), the beat that takes the last free buffer slot is presented with `in_stop` high. That beat is stored and the burst closes with byte count = 8 × beats received.
- R5: In extended mode (`pcix_mode`=1), `in_stop` is high on a beat whose address bits [6:3] are all ones when at most 16 beat slots are free, counting that beat. It is also high whenever only one slot is free. The burst closes on that beat.
- R6: During replay, `out_addr` is the burst start address and `out_bytes` is 8 × beats received. `out_cmd` is the requested command (0 = plain write, 1 = write-and-invalidate) in conventional mode and is forced to 0 in extended mode. Data and byte enables come out beat for beat as written.
- R7: Transactions drain strictly in arrival order, and no drain starts while `out_grant` is low.
- R8: A transaction's descriptor slot and buffer space are released only when its last beat is taken (`out_valid & out_ready & out_last`), or when it is aborted.
- R9: `out_abort` while `out_busy` drops only the head transaction and releases its space. Later transactions replay intact and in order.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_be` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pcix_mode | input | 1 | 1 = extended protocol mode, sampled at admission |
| in_start | input | 1 | New write claimed on the bus |
| in_addr | input | 32 | Start byte address (beat aligned) |
| in_cmd | input | 1 | 0 plain write, 1 write-and-invalidate |
| in_accept | output | 1 | Admission granted (one-cycle pulse) |
| in_retry | output | 1 | Admission refused (one-cycle pulse) |
| in_valid | input | 1 | Ingress data beat present |
| in_data | input | 64 | Ingress data beat |
| in_be | input | 8 | Ingress byte enables |
| in_last | input | 1 | Final beat of the burst |
| in_stop | output | 1 | Current beat is the last one taken |
| out_grant | input | 1 | Ownership and ordering permission for egress |
| out_busy | output | 1 | A head transaction is being replayed |
| out_addr | output | 32 | Start address of the replayed transaction |
| out_cmd | output | 1 | Command of the replayed transaction |
| out_bytes | output | 13 | Byte count of the replayed transaction |
| out_valid | output | 1 | Egress beat valid |
| out_data | output | 64 | Egress data beat |
| out_be | output | 8 | Egress byte enables |
| out_last | output | 1 | Final beat of the transaction |
| out_ready | input | 1 | Internal target takes the beat |
| out_abort | input | 1 | Cancel the head transaction |

## Verification
A fault in the occupancy count shows up within one burst. `in_stop` fires on the wrong beat, so the replayed byte count moves away from the computed 4096, 4032 or 3976 bytes. A fault in the descriptor or read pointers shows up on the next replay as a wrong `out_addr`, a wrong order, or data that carries another burst's signature. After an abort, any wrong rebase appears on the very next transaction's first beat. A release that fires early or late changes the retry/accept answer to a fifth write while the head is still stalled.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
  typedef enum logic {CMD_MEM_WR = 1'b0, CMD_MEM_WR_INV = 1'b1} wr_cmd_e;
  typedef enum logic {ING_IDLE = 1'b0, ING_BURST = 1'b1} ing_state_e;
  typedef enum logic {EG_IDLE = 1'b0, EG_DRAIN = 1'b1} eg_state_e;
endpackage

// File: rtl/pwq_data_buf.sv
module pwq_data_buf #(
  parameter int WIDTH = 72,
  parameter int DEPTH = 512
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwq_desc_queue.sv
module pwq_desc_queue import pwq_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [ADDR_W-1:0]          push_addr,
  input  wr_cmd_e                    push_cmd,
  input  logic [LEN_W-1:0]           push_len,
  input  logic                       pop,
  output logic [ADDR_W-1:0]          head_addr,
  output wr_cmd_e                    head_cmd,
  output logic [LEN_W-1:0]           head_len,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_r [DEPTH];
  wr_cmd_e           cmd_r  [DEPTH];
  logic [LEN_W-1:0]  len_r  [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_r[wp_q] <= push_addr;
      cmd_r[wp_q]  <= push_cmd;
      len_r[wp_q]  <= push_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assign head_addr = addr_r[rp_q];
  assign head_cmd  = cmd_r[rp_q];
  assign head_len  = len_r[rp_q];
  assign count     = cnt_q;
endmodule

// File: rtl/pwq_ingress.sv
module pwq_ingress import pwq_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int BE_W       = 8,
  parameter int BUF_BEATS  = 512,
  parameter int DESC_DEPTH = 4,
  parameter int ADB_BYTES  = 128
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            pcix_mode,
  input  logic                            in_start,
  input  logic [ADDR_W-1:0]               in_addr,
  input  logic                            in_cmd,
  input  logic                            in_valid,
  input  logic                            in_last,
  input  logic [$clog2(DESC_DEPTH+1)-1:0] desc_cnt,
  input  logic [$clog2(BUF_BEATS+1)-1:0]  free_beats,
  output logic                            in_accept,
  output logic                            in_retry,
  output logic                            in_stop,
  output logic                            buf_we,
  output logic [$clog2(BUF_BEATS)-1:0]    buf_waddr,
  output logic                            push,
  output logic [ADDR_W-1:0]               push_addr,
  output wr_cmd_e                         push_cmd,
  output logic [$clog2(BUF_BEATS+1)-1:0]  push_len
);
  localparam int PTR_W     = $clog2(BUF_BEATS);
  localparam int LEN_W     = $clog2(BUF_BEATS + 1);
  localparam int CNT_W     = $clog2(DESC_DEPTH + 1);
  localparam int BEAT_LSB  = $clog2(BE_W);
  localparam int ADB_BEATS = ADB_BYTES / BE_W;
  localparam int ADB_HI    = $clog2(ADB_BYTES) - 1;
  localparam int WIN_W     = ADB_HI - BEAT_LSB + 1;

  ing_state_e        st_q;
  logic              pcix_q;
  wr_cmd_e           cmd_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  beats_q;
  logic [WIN_W-1:0]  win_q;
  logic [PTR_W-1:0]  wptr_q;
  logic              burst, slot_free, room, win_end, beat, close;

  assign burst     = (st_q == ING_BURST);
  assign slot_free = (desc_cnt < CNT_W'(DESC_DEPTH));
  assign room      = (free_beats != '0);
  assign win_end   = &win_q;
  assign in_stop   = burst && ((free_beats == LEN_W'(1)) ||
                     (pcix_q && win_end && (free_beats <= LEN_W'(ADB_BEATS))));
  assign beat      = burst && in_valid;
  assign close     = beat && (in_last || in_stop);

  assign buf_we    = beat;
  assign buf_waddr = wptr_q;
  assign push      = close;
  assign push_addr = start_q;
  assign push_cmd  = cmd_q;
  assign push_len  = beats_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ING_IDLE;
      in_accept <= 1'b0;
      in_retry  <= 1'b0;
      pcix_q    <= 1'b0;
      cmd_q     <= CMD_MEM_WR;
      start_q   <= '0;
      beats_q   <= '0;
      win_q     <= '0;
      wptr_q    <= '0;
    end else begin
      in_accept <= 1'b0;
      in_retry  <= 1'b0;
      if (!burst && in_start) begin
        if (slot_free && room) begin
          in_accept <= 1'b1;
          st_q      <= ING_BURST;
          start_q   <= in_addr;
          cmd_q     <= pcix_mode ? CMD_MEM_WR : wr_cmd_e'(in_cmd);
          pcix_q    <= pcix_mode;
          beats_q   <= '0;
          win_q     <= in_addr[ADB_HI:BEAT_LSB];
        end else begin
          in_retry  <= 1'b1;
        end
      end
      if (beat) begin
        wptr_q  <= wptr_q + 1'b1;
        beats_q <= beats_q + 1'b1;
        win_q   <= win_q + 1'b1;
        if (close) st_q <= ING_IDLE;
      end
    end
  end
endmodule

// File: rtl/pwq_egress.sv
module pwq_egress import pwq_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int BE_W      = 8,
  parameter int BUF_BEATS = 512
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     out_grant,
  input  logic                                     out_ready,
  input  logic                                     out_abort,
  input  logic                                     have_desc,
  input  logic [ADDR_W-1:0]                        head_addr,
  input  wr_cmd_e                                  head_cmd,
  input  logic [$clog2(BUF_BEATS+1)-1:0]           head_len,
  output logic                                     pop,
  output logic                                     buf_re,
  output logic [$clog2(BUF_BEATS)-1:0]             buf_raddr,
  output logic                                     out_busy,
  output logic [ADDR_W-1:0]                        out_addr,
  output logic                                     out_cmd,
  output logic [$clog2(BUF_BEATS+1)+$clog2(BE_W)-1:0] out_bytes,
  output logic                                     out_valid,
  output logic                                     out_last
);
  localparam int PTR_W    = $clog2(BUF_BEATS);
  localparam int LEN_W    = $clog2(BUF_BEATS + 1);
  localparam int BEAT_LSB = $clog2(BE_W);

  eg_state_e        st_q;
  logic [PTR_W-1:0] rptr_q, base_q, next_base;
  logic [LEN_W-1:0] left_q;
  logic             drain, done;

  assign drain     = (st_q == EG_DRAIN);
  assign done      = out_valid && out_ready && out_last;
  assign pop       = drain && (out_abort || done);
  assign buf_re    = drain && !out_abort && (left_q != '0) && (!out_valid || out_ready);
  assign buf_raddr = rptr_q;
  assign next_base = base_q + PTR_W'(head_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= EG_IDLE;
      rptr_q    <= '0;
      base_q    <= '0;
      left_q    <= '0;
      out_busy  <= 1'b0;
      out_addr  <= '0;
      out_cmd   <= 1'b0;
      out_bytes <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else if (!drain) begin
      if (out_grant && have_desc) begin
        st_q      <= EG_DRAIN;
        out_busy  <= 1'b1;
        out_addr  <= head_addr;
        out_cmd   <= head_cmd;
        out_bytes <= {head_len, {BEAT_LSB{1'b0}}};
        left_q    <= head_len;
        rptr_q    <= base_q;
      end
    end else if (out_abort || done) begin
      st_q      <= EG_IDLE;
      out_busy  <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      left_q    <= '0;
      base_q    <= next_base;
      rptr_q    <= next_base;
    end else if (buf_re) begin
      rptr_q    <= rptr_q + 1'b1;
      left_q    <= left_q - 1'b1;
      out_valid <= 1'b1;
      out_last  <= (left_q == LEN_W'(1));
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/posted_wr_queue.sv
module posted_wr_queue import pwq_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int BUF_BYTES  = 4096,
  parameter int DESC_DEPTH = 4,
  parameter int ADB_BYTES  = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pcix_mode,
  input  logic                     in_start,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic                     in_cmd,
  output logic                     in_accept,
  output logic                     in_retry,
  input  logic                     in_valid,
  input  logic [DATA_W-1:0]        in_data,
  input  logic [DATA_W/8-1:0]      in_be,
  input  logic                     in_last,
  output logic                     in_stop,
  input  logic                     out_grant,
  output logic                     out_busy,
  output logic [ADDR_W-1:0]        out_addr,
  output logic                     out_cmd,
  output logic [$clog2(BUF_BYTES/(DATA_W/8)+1)+$clog2(DATA_W/8)-1:0] out_bytes,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic [DATA_W/8-1:0]      out_be,
  output logic                     out_last,
  input  logic                     out_ready,
  input  logic                     out_abort
);
  localparam int BE_W      = DATA_W / 8;
  localparam int BUF_BEATS = BUF_BYTES / BE_W;
  localparam int PTR_W     = $clog2(BUF_BEATS);
  localparam int LEN_W     = $clog2(BUF_BEATS + 1);
  localparam int CNT_W     = $clog2(DESC_DEPTH + 1);
  localparam int WORD_W    = DATA_W + BE_W;

  logic              buf_we, buf_re, push, pop;
  logic [PTR_W-1:0]  buf_waddr, buf_raddr;
  logic [WORD_W-1:0] buf_rdata;
  logic [ADDR_W-1:0] push_addr, head_addr;
  wr_cmd_e           push_cmd, head_cmd;
  logic [LEN_W-1:0]  push_len, head_len;
  logic [CNT_W-1:0]  desc_cnt;
  logic [LEN_W-1:0]  used_beats, free_beats;

  assign free_beats = LEN_W'(BUF_BEATS) - used_beats;

  always_ff @(posedge clk) begin
    if (rst) used_beats <= '0;
    else     used_beats <= used_beats + LEN_W'(buf_we) - (pop ? head_len : '0);
  end

  pwq_ingress #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .BUF_BEATS(BUF_BEATS),
    .DESC_DEPTH(DESC_DEPTH), .ADB_BYTES(ADB_BYTES)
  ) u_ingress (
    .clk(clk), .rst(rst), .pcix_mode(pcix_mode), .in_start(in_start),
    .in_addr(in_addr), .in_cmd(in_cmd), .in_valid(in_valid), .in_last(in_last),
    .desc_cnt(desc_cnt), .free_beats(free_beats), .in_accept(in_accept),
    .in_retry(in_retry), .in_stop(in_stop), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .push(push), .push_addr(push_addr), .push_cmd(push_cmd), .push_len(push_len)
  );

  pwq_data_buf #(.WIDTH(WORD_W), .DEPTH(BUF_BEATS)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata({in_be, in_data}),
    .re(buf_re), .raddr(buf_raddr), .rdata(buf_rdata)
  );

  pwq_desc_queue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DESC_DEPTH)) u_desc (
    .clk(clk), .rst(rst), .push(push), .push_addr(push_addr), .push_cmd(push_cmd),
    .push_len(push_len), .pop(pop), .head_addr(head_addr), .head_cmd(head_cmd),
    .head_len(head_len), .count(desc_cnt)
  );

  pwq_egress #(.ADDR_W(ADDR_W), .BE_W(BE_W), .BUF_BEATS(BUF_BEATS)) u_egress (
    .clk(clk), .rst(rst), .out_grant(out_grant), .out_ready(out_ready),
    .out_abort(out_abort), .have_desc(desc_cnt != '0), .head_addr(head_addr),
    .head_cmd(head_cmd), .head_len(head_len), .pop(pop), .buf_re(buf_re),
    .buf_raddr(buf_raddr), .out_busy(out_busy), .out_addr(out_addr),
    .out_cmd(out_cmd), .out_bytes(out_bytes), .out_valid(out_valid),
    .out_last(out_last)
  );

  assign out_data = buf_rdata[DATA_W-1:0];
  assign out_be   = buf_rdata[WORD_W-1:DATA_W];
endmodule

// File: rtl/posted_wr_queue_chk.sv
module posted_wr_queue_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BUF_BEATS = 512,
  parameter int LEN_W     = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_start,
  input logic              in_accept,
  input logic              in_retry,
  input logic              out_busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic              out_abort,
  input logic [DATA_W-1:0] out_data,
  input logic [ADDR_W-1:0] out_addr,
  input logic [LEN_W-1:0]  used_beats
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    used_beats <= LEN_W'(BUF_BEATS));

  assert_single_answer_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_accept, in_retry}));

  assert_answer_after_start_R2: assert property (@(posedge clk) disable iff (rst)
    (in_accept || in_retry) |-> $past(in_start));

  assert_valid_needs_busy_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_busy);

  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !out_abort) |=> (out_valid && $stable(out_data)));

  assert_addr_held_R6: assert property (@(posedge clk) disable iff (rst)
    (out_busy && !out_abort && !(out_valid && out_ready && out_last))
      |=> (out_busy && $stable(out_addr)));

  assert_release_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(out_busy) |-> ($past(out_abort) || $past(out_valid && out_ready && out_last)));
endmodule

bind posted_wr_queue posted_wr_queue_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_BEATS(BUF_BEATS), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .in_start(in_start), .in_accept(in_accept),
  .in_retry(in_retry), .out_busy(out_busy), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_abort(out_abort),
  .out_data(out_data), .out_addr(out_addr), .used_beats(used_beats)
);

// File: tb/posted_wr_queue_tb.sv
module posted_wr_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pcix_mode = 1'b0, in_start = 1'b0, in_cmd = 1'b0;
  logic [31:0] in_addr = '0;
  logic        in_accept, in_retry, in_stop;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_be = '0;
  logic        out_grant = 1'b0, out_ready = 1'b0, out_abort = 1'b0;
  logic        out_busy, out_cmd, out_valid, out_last;
  logic [31:0] out_addr;
  logic [12:0] out_bytes;
  logic [63:0] out_data;
  logic [7:0]  out_be;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  posted_wr_queue u_dut (
    .clk(clk), .rst(rst), .pcix_mode(pcix_mode), .in_start(in_start),
    .in_addr(in_addr), .in_cmd(in_cmd), .in_accept(in_accept), .in_retry(in_retry),
    .in_valid(in_valid), .in_data(in_data), .in_be(in_be), .in_last(in_last),
    .in_stop(in_stop), .out_grant(out_grant), .out_busy(out_busy),
    .out_addr(out_addr), .out_cmd(out_cmd), .out_bytes(out_bytes),
    .out_valid(out_valid), .out_data(out_data), .out_be(out_be),
    .out_last(out_last), .out_ready(out_ready), .out_abort(out_abort)
  );

  typedef struct packed {
    logic        mode;
    logic [31:0] addr;
    logic        cmd;
    logic [15:0] nbeats;
    logic [15:0] expb;
    logic        ecmd;
  } vec_t;

  // mode, start address, command, beats offered, beats expected taken, command expected
  localparam vec_t VEC [6] = '{
    '{1'b0, 32'h0000_1000, 1'b0, 16'd4,   16'd4,   1'b0},
    '{1'b0, 32'h0000_2008, 1'b1, 16'd1,   16'd1,   1'b1},
    '{1'b1, 32'h0000_3000, 1'b1, 16'd20,  16'd20,  1'b0},
    '{1'b0, 32'h0000_0040, 1'b0, 16'd600, 16'd512, 1'b0},
    '{1'b1, 32'h0000_0040, 1'b0, 16'd600, 16'd504, 1'b0},
    '{1'b1, 32'h0000_0078, 1'b0, 16'd600, 16'd497, 1'b0}
  };

  function automatic logic [63:0] beat_data(input logic [31:0] a, input int k);
    return {a, 32'(k) ^ 32'hA5A5_0000};
  endfunction

  function automatic logic [7:0] beat_be(input int k);
    return 8'(k * 37 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_write(input logic mode, input logic [31:0] a, input logic c,
                             output bit acc, output bit ret);
    @(negedge clk);
    pcix_mode = mode;
    in_addr   = a;
    in_cmd    = c;
    in_start  = 1'b1;
    @(negedge clk);
    in_start = 1'b0;
    acc = in_accept;
    ret = in_retry;
  endtask

  task automatic send_beats(input logic [31:0] a, input int n, output int taken);
    taken = 0;
    for (int k = 0; k < n; k++) begin
      bit stop;
      in_valid = 1'b1;
      in_data  = beat_data(a, k);
      in_be    = beat_be(k);
      in_last  = (k == n - 1);
      stop     = in_stop;
      @(negedge clk);
      taken++;
      if (stop) break;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic write_burst(input logic mode, input logic [31:0] a, input logic c,
                             input int n, input string req, output int taken);
    bit acc, ret;
    start_write(mode, a, c, acc, ret);
    chk(acc && !ret, req, "admission", {acc, ret}, 2'b10);
    taken = 0;
    if (acc) send_beats(a, n, taken);
  endtask

  task automatic drain_one(input logic [31:0] a, input logic c, input int nb,
                           input int abort_at, input bit bp, input string req);
    int got = 0;
    int errs = 0;
    int cyc = 0;
    while (!out_busy) @(negedge clk);
    chk(out_addr == a, req, "replay address", out_addr, a);
    chk(out_cmd == c, req, "replay command", out_cmd, c);
    chk(out_bytes == 13'(nb * 8), req, "replay byte count", out_bytes, nb * 8);
    out_ready = bp ? 1'b0 : 1'b1;
    forever begin
      bit fire, lastb;
      if (abort_at >= 0 && got == abort_at) begin
        out_abort = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        out_abort = 1'b0;
        break;
      end
      fire  = out_valid && out_ready;
      lastb = out_last;
      if (fire && (out_data != beat_data(a, got) || out_be != beat_be(got))) errs++;
      @(negedge clk);
      cyc++;
      if (fire) begin
        got++;
        if (lastb) break;
      end
      if (bp) out_ready = (cyc % 3 != 0);
    end
    out_ready = 1'b0;
    chk(errs == 0, req, "replayed beat mismatches", errs, 0);
    chk(got == ((abort_at >= 0) ? abort_at : nb), req, "beats replayed", got,
        (abort_at >= 0) ? abort_at : nb);
    chk(!out_busy, "R8", "busy released after completion", out_busy, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=<%0d cycles", MAX_CYCLES, MAX_CYCLES);
    finish_run();
  end

  initial begin
    int taken;
    bit acc, ret;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!in_accept && !in_retry && !in_stop, "R1", "ingress idle after reset",
        {in_accept, in_retry, in_stop}, 0);
    chk(!out_busy && !out_valid && !out_last, "R1", "egress idle after reset",
        {out_busy, out_valid, out_last}, 0);

    // Vector table: write, check truncation point, then replay (R4 R5 R6)
    foreach (VEC[i]) begin
      write_burst(VEC[i].mode, VEC[i].addr, VEC[i].cmd, int'(VEC[i].nbeats),
                  VEC[i].mode ? "R5" : "R4", taken);
      chk(taken == int'(VEC[i].expb), VEC[i].mode ? "R5" : "R4",
          "beats taken before stop", taken, VEC[i].expb);
      out_grant = 1'b1;
      drain_one(VEC[i].addr, VEC[i].ecmd, int'(VEC[i].expb), -1, 1'b0, "R6");
      out_grant = 1'b0;
    end

    // R2: four resident transactions, fifth refused; R7: no drain without grant
    for (int t = 0; t < 4; t++) begin
      write_burst(1'b0, 32'h0001_0000 + 32'(t) * 32'h100, 1'b0, 3, "R2", taken);
    end
    start_write(1'b0, 32'h0002_0000, 1'b0, acc, ret);
    chk(ret && !acc, "R2", "fifth write refused", {acc, ret}, 2'b01);
    repeat (8) @(negedge clk);
    chk(!out_busy && !out_valid, "R7", "no drain while grant low", out_busy, 0);

    // R8: head stalled, slot not yet released
    out_grant = 1'b1;
    while (!out_valid) @(negedge clk);
    start_write(1'b0, 32'h0002_0000, 1'b0, acc, ret);
    chk(ret && !acc, "R8", "refused while head unfinished", {acc, ret}, 2'b01);

    // R7 order, R10 backpressure
    for (int t = 0; t < 4; t++) begin
      drain_one(32'h0001_0000 + 32'(t) * 32'h100, 1'b0, 3, -1, 1'b1, "R10");
    end
    out_grant = 1'b0;
    write_burst(1'b0, 32'h0002_0000, 1'b1, 2, "R8", taken);
    out_grant = 1'b1;
    drain_one(32'h0002_0000, 1'b1, 2, -1, 1'b0, "R7");
    out_grant = 1'b0;

    // R9: abort head, later transactions intact
    write_burst(1'b0, 32'h0003_0000, 1'b0, 4, "R9", taken);
    write_burst(1'b0, 32'h0003_1000, 1'b0, 3, "R9", taken);
    write_burst(1'b1, 32'h0003_2000, 1'b1, 2, "R9", taken);
    out_grant = 1'b1;
    drain_one(32'h0003_0000, 1'b0, 4, 2, 1'b0, "R9");
    drain_one(32'h0003_1000, 1'b0, 3, -1, 1'b0, "R9");
    drain_one(32'h0003_2000, 1'b0, 2, -1, 1'b0, "R9");
    out_grant = 1'b0;

    // R3/R9: aborted space released, full buffer available again
    write_burst(1'b0, 32'h0004_0000, 1'b0, 700, "R3", taken);
    chk(taken == 512, "R3", "full-capacity burst after abort", taken, 512);
    out_grant = 1'b1;
    drain_one(32'h0004_0000, 1'b0, 512, -1, 1'b0, "R3");
    out_grant = 1'b0;

    finish_run();
  end
endmodule